// File: doc/BRIEF.md
# Flash Operation Control Register

This block is the single byte-wide control register that a CPU writes to steer program and erase cycles on a 16 KB on-chip flash array. It sits on a simple memory bus (address, write data, write strobe, combinational read data) and answers at one fixed address. Four low bits are kept: a program-select bit, an erase-select bit, a whole-array flag and a high-voltage enable. Hardware interlocks filter every write, so program and erase can never both be selected and the high voltage cannot be switched on before an operation has been chosen.

From the stored bits the block derives a pump enable and three one-hot mode strobes (program, page erase, whole-array erase) that are live only while the high voltage is on. It also watches bus writes into the flash window. The first such write after erase is selected latches the target page index for the erase sequencer. The interrupt-vector tail of the array is reported as one dedicated page ID.

Top module: `nvm_opctl`

## Requirements
- R1: After a synchronous active-low reset, all four stored bits are 0, all mode outputs and pump_en are 0, and erase_page is 0.
- R2: A read at CTL_ADDR (default 16'hFE08) returns {4'b0000, HV, WHOLE, ERASE, PROG}, with HV at bit 3, WHOLE at bit 2, ERASE at bit 1 and PROG at bit 0. A read at any other address returns 8'h00.
- R3: PROG and ERASE are never 1 together. A write with bit0=1 and bit1=1 while both are 0 leaves both at 0.
- R4: A write that would set PROG while ERASE is 1, or set ERASE while PROG is 1, leaves that bit at 0. Writing 0 to either bit always clears it.
- R5: HV can only go from 0 to 1 if PROG or ERASE was already 1 before the write. Otherwise bit3=1 is ignored.
- R6: A write that leaves PROG and ERASE both 0 also leaves HV at 0.
- R7: WHOLE (bit 2) takes the written value on every write to CTL_ADDR, with no interlock.
- R8: pump_en equals HV. mode_prog = HV&PROG, mode_page_erase = HV&ERASE&~WHOLE, mode_mass_erase = HV&ERASE&WHOLE. At most one mode output is 1 at a time.
- R9: After a write to CTL_ADDR moves ERASE from 0 to 1, the first bus write to an address in [ARRAY_BASE (16'hC000), 16'hFFFF] other than CTL_ADDR loads erase_page with {1'b0, addr[15:6]}. Later array writes do not change it until ERASE is set again. Clearing ERASE cancels a pending capture.
- R10: A captured address in the vector area 16'hFFDC..16'hFFFF loads erase_page with the dedicated ID 11'h400.
- R11: Writes to any address other than CTL_ADDR leave the four stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for the current address |
| pump_en | output | 1 | High-voltage pump enable |
| mode_prog | output | 1 | Program operation active |
| mode_page_erase | output | 1 | Single-page erase active |
| mode_mass_erase | output | 1 | Whole-array erase active |
| erase_page | output | 11 | Latched erase page ID (bit 10 marks the vector page) |

## Verification
A wrong interlock decision shows up in the register readback and the mode strobes on the first cycle after the faulty write. A bad arming of the page latch stays hidden until the next write into the array window, and then appears on erase_page one cycle later. Any stored bit that drifts without a write to the register also shows at once on bus_rdata. The bench therefore reads the register back after every transaction.

// File: rtl/nvm_opctl_pkg.sv
// Package: shared field layout of the flash operation control byte.
// Assumes the bit positions below are fixed, because software decodes them.
package nvm_opctl_pkg;
    localparam int BIT_PROG  = 0;
    localparam int BIT_ERASE = 1;
    localparam int BIT_WHOLE = 2;
    localparam int BIT_HV    = 3;

    typedef struct packed {
        logic hv;
        logic whole;
        logic erase;
        logic prog;
    } ctl_bits_t;
endpackage

// File: rtl/nvm_opctl_regs.sv
// Module: stored control bits with write interlocks.
// Assumes at most one bus write per cycle. Reset is synchronous, active low.
module nvm_opctl_regs
    import nvm_opctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output ctl_bits_t         bits,
    output logic              erase_set
);
    ctl_bits_t cur, nxt;
    logic w_p, w_e, n_p, n_e;

    // Purpose: work out the interlocked next value for a register write.
    always_comb begin
        w_p = wdata[BIT_PROG];
        w_e = wdata[BIT_ERASE];
        n_p = w_p & (cur.prog  | (~cur.erase & ~w_e));
        n_e = w_e & (cur.erase | (~cur.prog  & ~w_p));
        nxt = cur;
        if (wr_hit) begin
            nxt.prog  = n_p;
            nxt.erase = n_e;
            nxt.whole = wdata[BIT_WHOLE];
            nxt.hv    = wdata[BIT_HV] & (cur.prog | cur.erase) & (n_p | n_e);
        end
    end

    // Purpose: hold the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    assign bits      = cur;
    assign erase_set = wr_hit & n_e & ~cur.erase;

    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur.prog && cur.erase));
    a_r5_hv_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur.hv) |-> $past(cur.prog || cur.erase));
    a_r6_hv_alone: assert property (@(posedge clk) disable iff (!rst_n)
        cur.hv |-> (cur.prog || cur.erase));
    a_r11_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(cur));
endmodule

// File: rtl/nvm_opctl_page.sv
// Module: erase page latch. It arms when erase is newly selected and captures
// the page of the next array write. Assumes one write per cycle and that
// arming and capture never fall in the same cycle (they use different addresses).
module nvm_opctl_page #(
    parameter int          ADDR_W   = 16,
    parameter int          PAGE_LSB = 6,
    parameter logic [15:0] VEC_BASE = 16'hFFDC,
    localparam int         PAGE_W   = ADDR_W - PAGE_LSB,
    localparam int         ID_W     = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              erase_on,
    input  logic              arr_wr,
    input  logic [ADDR_W-1:0] addr,
    output logic [ID_W-1:0]   page_id
);
    logic            armed;
    logic            cap;
    logic [ID_W-1:0] id_in;

    // Purpose: map a bus address to its page ID, with the vector tail as a dedicated page.
    always_comb begin
        if (addr >= ADDR_W'(VEC_BASE)) id_in = {1'b1, {PAGE_W{1'b0}}};
        else                           id_in = {1'b0, addr[ADDR_W-1:PAGE_LSB]};
        cap = armed & erase_on & arr_wr;
    end

    // Purpose: track whether a capture is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed <= 1'b0;
        else if (arm)       armed <= 1'b1;
        else if (!erase_on) armed <= 1'b0;
        else if (cap)       armed <= 1'b0;
    end

    // Purpose: latch the captured page ID.
    always_ff @(posedge clk) begin
        if (!rst_n)   page_id <= '0;
        else if (cap) page_id <= id_in;
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(page_id));
    a_r9_once: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !armed);
endmodule

// File: rtl/nvm_opctl_decode.sv
// Module: turns the stored bits into the pump enable and the one-hot mode strobes.
// Assumes the bits come from nvm_opctl_regs, so program and erase are exclusive.
module nvm_opctl_decode
    import nvm_opctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ctl_bits_t bits,
    output logic      pump_en,
    output logic      m_prog,
    output logic      m_page,
    output logic      m_whole
);
    // Purpose: gate each mode with the high-voltage enable.
    always_comb begin
        pump_en = bits.hv;
        m_prog  = bits.hv & bits.prog;
        m_page  = bits.hv & bits.erase & ~bits.whole;
        m_whole = bits.hv & bits.erase &  bits.whole;
    end

    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_prog, m_page, m_whole}));
    a_r8_needs_pump: assert property (@(posedge clk) disable iff (!rst_n)
        (m_prog || m_page || m_whole) |-> pump_en);
endmodule

// File: rtl/nvm_opctl.sv
// Module: top of the flash operation control register. It decodes the register
// address and the array window, and wires the register, page latch and mode decode together.
// Assumes a combinational read path and one bus access per cycle.
module nvm_opctl
    import nvm_opctl_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter logic [15:0] CTL_ADDR   = 16'hFE08,
    parameter logic [15:0] ARRAY_BASE = 16'hC000,
    parameter logic [15:0] VEC_BASE   = 16'hFFDC,
    parameter int          PAGE_LSB   = 6,
    localparam int         ID_W       = ADDR_W - PAGE_LSB + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pump_en,
    output logic              mode_prog,
    output logic              mode_page_erase,
    output logic              mode_mass_erase,
    output logic [ID_W-1:0]   erase_page
);
    ctl_bits_t bits;
    logic      is_ctl, wr_hit, arr_wr, erase_set;

    // Purpose: decode the register address and the flash array window.
    always_comb begin
        is_ctl = (bus_addr == ADDR_W'(CTL_ADDR));
        wr_hit = bus_we & is_ctl;
        arr_wr = bus_we & ~is_ctl & (bus_addr >= ADDR_W'(ARRAY_BASE));
    end

    // Purpose: return the register byte at its address and zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (is_ctl) bus_rdata[3:0] = bits;
    end

    nvm_opctl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(bus_wdata),
        .bits(bits), .erase_set(erase_set)
    );

    nvm_opctl_page #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .VEC_BASE(VEC_BASE)) u_page (
        .clk(clk), .rst_n(rst_n), .arm(erase_set), .erase_on(bits.erase),
        .arr_wr(arr_wr), .addr(bus_addr), .page_id(erase_page)
    );

    nvm_opctl_decode u_dec (
        .clk(clk), .rst_n(rst_n), .bits(bits), .pump_en(pump_en),
        .m_prog(mode_prog), .m_page(mode_page_erase), .m_whole(mode_mass_erase)
    );

    a_r2_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ctl |-> (bus_rdata == '0));
endmodule

// File: tb/test_nvm_opctl.sv
module test_nvm_opctl;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] CTL = 16'hFE08;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] bus_addr = 0;
    logic [7:0]  bus_wdata = 0;
    logic        bus_we = 0;
    logic [7:0]  bus_rdata;
    logic        pump_en, mode_prog, mode_page_erase, mode_mass_erase;
    logic [10:0] erase_page;

    int n_run = 0, n_fail = 0;
    logic m_p = 0, m_e = 0, m_hv = 0, m_wh = 0, m_arm = 0;
    logic [10:0] m_page = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_opctl i_nvm_opctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pump_en(pump_en),
        .mode_prog(mode_prog), .mode_page_erase(mode_page_erase),
        .mode_mass_erase(mode_mass_erase), .erase_page(erase_page)
    );

    function automatic logic [10:0] page_of(logic [15:0] a);
        return (a >= 16'hFFDC) ? 11'h400 : {1'b0, a[15:6]};
    endfunction

    function automatic logic [7:0] exp_byte();
        return {4'b0000, m_hv, m_wh, m_e, m_p};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model the effect of one bus write (computed from the requirements).
    task automatic model_write(logic [15:0] a, logic [7:0] d);
        logic np, ne;
        if (a == CTL) begin
            np = d[0] & (m_p | (~m_e & ~d[1]));          // R3, R4
            ne = d[1] & (m_e | (~m_p & ~d[0]));
            m_hv = d[3] & (m_p | m_e) & (np | ne);        // R5, R6
            if (ne && !m_e) m_arm = 1;
            else if (!ne) m_arm = 0;
            m_p = np; m_e = ne; m_wh = d[2];              // R7
        end else if (a >= 16'hC000 && m_arm && m_e) begin // R9, R10
            m_page = page_of(a);
            m_arm = 0;
        end
    endtask

    task automatic check_all(string tag);
        bus_addr = CTL; #1;
        check({tag, " R2 readback"}, bus_rdata, exp_byte());
        check({tag, " R8 pump"}, pump_en, m_hv);
        check({tag, " R8 modes"}, {mode_prog, mode_page_erase, mode_mass_erase},
              {m_hv & m_p, m_hv & m_e & ~m_wh, m_hv & m_e & m_wh});
        check({tag, " R9 page"}, erase_page, m_page);
    endtask

    task automatic bus_write(logic [15:0] a, logic [7:0] d, string tag);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
        model_write(a, d);
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] a;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");
        bus_addr = 16'h1234; #1;
        check("R2 other addr", bus_rdata, 8'h00);

        bus_write(CTL, 8'h03, "R3 both set");
        check("R3 both zero", bus_rdata[1:0], 2'b00);
        bus_write(CTL, 8'h08, "R5 hv alone");
        check("R5 hv ignored", bus_rdata[3], 1'b0);
        bus_write(CTL, 8'h09, "R5 hv with prog");
        check("R5 hv same write", bus_rdata[3], 1'b0);
        bus_write(CTL, 8'h09, "R5 hv after prog");
        check("R5 hv set", bus_rdata[3], 1'b1);
        bus_write(CTL, 8'h0B, "R4 erase on prog");
        check("R4 erase rejected", bus_rdata[1:0], 2'b01);
        bus_write(16'h0040, 8'h00, "R11 stray");
        check("R11 unchanged", bus_rdata, 8'h09);
        bus_write(CTL, 8'h08, "R6 clear");
        check("R6 hv dropped", bus_rdata, 8'h00);
        bus_write(CTL, 8'h06, "R7 whole erase");
        bus_write(CTL, 8'h0E, "R8 mass");
        check("R8 mass strobe", mode_mass_erase, 1'b1);
        bus_write(16'hFFE0, 8'hAA, "R10 vector");
        check("R10 vector id", erase_page, 11'h400);
        bus_write(16'hC100, 8'hAA, "R9 second write");
        check("R9 not recaptured", erase_page, 11'h400);
        bus_write(CTL, 8'h00, "R4 clear");
        bus_write(CTL, 8'h02, "R9 rearm");
        bus_write(16'hD0C5, 8'h00, "R9 capture");
        check("R9 page idx", erase_page, 11'h343);

        for (int i = 0; i < 400; i++) begin
            int sel = $urandom_range(0, 99);
            if (sel < 55)      a = CTL;
            else if (sel < 80) a = 16'hC000 | 16'($urandom_range(0, 16'h3FFF));
            else if (sel < 92) a = 16'hFFDC + 16'($urandom_range(0, 35));
            else               a = 16'($urandom_range(0, 16'hBFFF));
            bus_write(a, 8'($urandom), "rand");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule